// File: doc/BRIEF.md
# Predicated Vector Byte Load Sequencer

This block carries out a predicated, contiguous load of unsigned bytes into one vector register. The caller supplies a start pulse together with a 64-bit scalar base address, a 64-bit scalar index, a predicate mask and an element-size select. The block latches these operands and walks the elements in ascending order. For each active element it issues a single-byte read on a valid/ready request channel and waits for the byte on a response channel. The returned byte is zero-extended into that element's field of the result.

Inactive elements never reach memory, and their fields read as zero. The index is offset by the element number when each address is formed, but the supplied value itself is never changed or returned. When the base comes from the stack pointer, a misaligned base can end the operation early with a fault. The result, together with the fault flag, is presented when the one-cycle completion pulse appears.

Top module: `lbs_vec_byte_load`

## Requirements
- R1: The element count is VLEN divided by the element width. Element-size select 0, 1, 2 and 3 gives widths of 8, 16, 32 and 64 bits. With every predicate bit set, exactly that many reads are issued.
- R2: Active element e reads one byte at address base + index + e, with 64-bit wraparound. Reads are issued in ascending element order, and only one is outstanding at any time.
- R3: The byte returned for element e is zero-extended and placed in result bits [e*W +: W], where W is the element width.
- R4: Element e is active when predicate bit e*(W/8) is set. An inactive element issues no read, and its result field is zero.
- R5: With the stack-pointer flag set, at least one active element and a nonzero base[3:0], the operation issues no read. It then asserts the fault output together with done, and the result is zero.
- R6: With the stack-pointer flag set, no active element and a nonzero base[3:0], a fault is reported only when the idle-check input is 1. When that input is 0, done arrives without a fault. In both cases the result is zero and no read is issued.
- R7: A start pulse that arrives while busy is high is ignored. The operands latched at the original start determine the reads and the result.
- R8: done lasts exactly one cycle. A pending read holds rd_valid_o high with a stable address until rd_ready_i is seen. After reset, done, rd_valid_o, busy and the result are all zero.
- R9: When the stack-pointer flag is clear, no fault is raised whatever the alignment of the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_i | input | AW | Scalar base address |
| base_is_sp_i | input | 1 | Base comes from the stack pointer |
| index_i | input | AW | Scalar index added to the base |
| pred_i | input | VLEN/8 | Predicate, one bit per byte of vector length |
| esz_i | input | 2 | Element width select (0:8, 1:16, 2:32, 3:64) |
| sp_chk_idle_i | input | 1 | Check stack-pointer alignment even when no element is active |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Byte address of the read |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Alignment fault, valid with done |
| result_o | output | VLEN | Assembled vector result |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted request, and only after that request's handshake. The sequencer itself keeps no count of outstanding reads. The bench responder enforces this assumption: it raises rsp_valid_i for a single cycle, at a randomized delay, and only after it has driven rd_ready_i for a request it has just checked. The bench changes the operand inputs as soon as start drops, which exposes any use of unlatched values. Elsewhere in the run it stalls rd_ready_i for a random number of cycles, so the hold rule on a pending request is exercised.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CHK  = 3'd1,
        ST_STEP = 3'd2,
        ST_REQ  = 3'd3,
        ST_WAIT = 3'd4,
        ST_FIN  = 3'd5
    } lbs_state_e;

    localparam int ALIGN_BITS = 4;
endpackage

// File: rtl/lbs_pred_gate.sv
module lbs_pred_gate #(
    parameter int PW = 16,
    parameter int CW = 5
) (
    input  logic [PW-1:0] pred,
    input  logic [1:0]    esz,
    input  logic [CW-1:0] elem,
    output logic          active,
    output logic          any_active
);
    logic [CW+2:0] pos;
    logic [PW-1:0] shifted;
    logic [PW-1:0] hit;

    // element e maps to predicate bit e * (W/8)
    always_comb begin
        pos     = {3'b000, elem} << esz;
        shifted = pred >> pos;
        active  = shifted[0];
    end

    for (genvar i = 0; i < PW; i++) begin : g_hit
        assign hit[i] = pred[i] && ((i % (1 << esz)) == 0);
    end

    assign any_active = |hit;
endmodule

// File: rtl/lbs_addr_gen.sv
module lbs_addr_gen #(
    parameter int AW = 64,
    parameter int CW = 5
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [CW-1:0] elem,
    output logic [AW-1:0] addr
);
    assign addr = base + index + {{(AW-CW){1'b0}}, elem};
endmodule

// File: rtl/lbs_lane_merge.sv
module lbs_lane_merge #(
    parameter int VLEN = 128,
    parameter int CW   = 5
) (
    input  logic [VLEN-1:0] acc,
    input  logic [1:0]      esz,
    input  logic [CW-1:0]   elem,
    input  logic [7:0]      data,
    output logic [VLEN-1:0] merged
);
    logic [CW+5:0]   sh;
    logic [VLEN-1:0] lane;

    always_comb begin
        sh     = {3'b000, elem, 3'b000} << esz;
        lane   = {{(VLEN-8){1'b0}}, data} << sh;
        merged = acc | lane;
    end
endmodule

// File: rtl/lbs_vec_byte_load.sv
module lbs_vec_byte_load #(
    parameter int VLEN = 128,
    parameter int AW   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       base_i,
    input  logic                base_is_sp_i,
    input  logic [AW-1:0]       index_i,
    input  logic [VLEN/8-1:0]   pred_i,
    input  logic [1:0]          esz_i,
    input  logic                sp_chk_idle_i,
    output logic                rd_valid_o,
    input  logic                rd_ready_i,
    output logic [AW-1:0]       rd_addr_o,
    input  logic                rsp_valid_i,
    input  logic [7:0]          rsp_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fault_o,
    output logic [VLEN-1:0]     result_o
);
    import lbs_pkg::*;

    localparam int PW = VLEN / 8;
    localparam int CW = $clog2(PW + 1);

    typedef struct packed {
        lbs_state_e      st;
        logic [CW-1:0]   elem;
        logic [AW-1:0]   base;
        logic [AW-1:0]   idx;
        logic [PW-1:0]   pred;
        logic [1:0]      esz;
        logic            sp;
        logic            chk_idle;
        logic            fault;
        logic [VLEN-1:0] res;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic            elem_active;
    logic            any_active;
    logic [AW-1:0]   addr;
    logic [VLEN-1:0] merged;
    logic [CW-1:0]   nelem;

    lbs_pred_gate #(.PW(PW), .CW(CW)) u_gate (
        .pred       (ctx_q.pred),
        .esz        (ctx_q.esz),
        .elem       (ctx_q.elem),
        .active     (elem_active),
        .any_active (any_active)
    );

    lbs_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .base  (ctx_q.base),
        .index (ctx_q.idx),
        .elem  (ctx_q.elem),
        .addr  (addr)
    );

    lbs_lane_merge #(.VLEN(VLEN), .CW(CW)) u_merge (
        .acc    (ctx_q.res),
        .esz    (ctx_q.esz),
        .elem   (ctx_q.elem),
        .data   (rsp_data_i),
        .merged (merged)
    );

    assign nelem = CW'(PW >> ctx_q.esz);

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.st       = ST_CHK;
                    ctx_d.elem     = '0;
                    ctx_d.base     = base_i;
                    ctx_d.idx      = index_i;
                    ctx_d.pred     = pred_i;
                    ctx_d.esz      = esz_i;
                    ctx_d.sp       = base_is_sp_i;
                    ctx_d.chk_idle = sp_chk_idle_i;
                    ctx_d.fault    = 1'b0;
                    ctx_d.res      = '0;
                end
            end
            ST_CHK: begin
                if (ctx_q.sp && (any_active || ctx_q.chk_idle) &&
                    (|ctx_q.base[ALIGN_BITS-1:0])) begin
                    ctx_d.fault = 1'b1;
                    ctx_d.st    = ST_FIN;
                end else begin
                    ctx_d.st = ST_STEP;
                end
            end
            ST_STEP: begin
                if (ctx_q.elem >= nelem) begin
                    ctx_d.st = ST_FIN;
                end else if (elem_active) begin
                    ctx_d.st = ST_REQ;
                end else begin
                    ctx_d.elem = ctx_q.elem + 1'b1;
                end
            end
            ST_REQ: begin
                if (rd_ready_i) ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    ctx_d.res  = merged;
                    ctx_d.elem = ctx_q.elem + 1'b1;
                    ctx_d.st   = ST_STEP;
                end
            end
            ST_FIN: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign rd_valid_o = (ctx_q.st == ST_REQ);
    assign rd_addr_o  = addr;
    assign busy_o     = (ctx_q.st != ST_IDLE);
    assign done_o     = (ctx_q.st == ST_FIN);
    assign fault_o    = done_o && ctx_q.fault;
    assign result_o   = ctx_q.res;

    // R4: a read is only ever presented for an element the predicate enables
    a_r4_req_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> elem_active);

    // R1: no read beyond the last element
    a_r1_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (ctx_q.elem < nelem));

    // R8: pending request keeps its address until accepted
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a fault only appears with done and never alongside a read
    a_r5_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (done_o && !rd_valid_o));

    // R9: no fault without the stack-pointer flag
    a_r9_no_fault_non_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ctx_q.sp) |-> !fault_o);

    // R7: start while busy leaves the latched operands alone
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ctx_q.base) && $stable(ctx_q.pred) &&
                                 $stable(ctx_q.idx) && $stable(ctx_q.esz)));
endmodule

// File: tb/tb_lbs_vec_byte_load.sv
module tb_lbs_vec_byte_load;
    localparam int VLEN = 64;
    localparam int AW   = 64;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   base_i = '0;
    logic            base_is_sp_i = 1'b0;
    logic [AW-1:0]   index_i = '0;
    logic [PW-1:0]   pred_i = '0;
    logic [1:0]      esz_i = '0;
    logic            sp_chk_idle_i = 1'b0;
    logic            rd_valid_o;
    logic            rd_ready_i = 1'b0;
    logic [AW-1:0]   rd_addr_o;
    logic            rsp_valid_i = 1'b0;
    logic [7:0]      rsp_data_i = '0;
    logic            busy_o;
    logic            done_o;
    logic            fault_o;
    logic [VLEN-1:0] result_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    lbs_vec_byte_load #(.VLEN(VLEN), .AW(AW)) dut (
        .clk, .rst_n, .start_i, .base_i, .base_is_sp_i, .index_i, .pred_i,
        .esz_i, .sp_chk_idle_i, .rd_valid_o, .rd_ready_i, .rd_addr_o,
        .rsp_valid_i, .rsp_data_i, .busy_o, .done_o, .fault_o, .result_o
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] esz, input logic [PW-1:0] pred,
                          input logic [63:0] base, input logic [63:0] idx,
                          input logic sp, input logic chk, input logic poke,
                          input string cnt_rq, input string flt_rq);
        int esize, nel, nact, e_ptr, nreq, cyc;
        logic [63:0] exp_res, a;
        logic exp_fault, got_done;
        esize = 8 << esz;
        nel   = VLEN / esize;
        nact  = 0;
        exp_res = '0;
        for (int e = 0; e < nel; e++) begin
            if (pred[e * (esize / 8)]) begin
                nact++;
                a = base + idx + 64'(e);
                exp_res = exp_res | (64'(mem_byte(a)) << (e * esize));
            end
        end
        exp_fault = sp && ((nact > 0) || chk) && (base[3:0] != 4'h0);
        if (exp_fault || (sp && base[3:0] != 4'h0)) begin
            if (exp_fault) exp_res = '0;
        end
        if (exp_fault) nact = 0;
        if (sp && nact == 0) exp_res = '0;

        @(negedge clk);
        start_i = 1'b1; esz_i = esz; pred_i = pred; base_i = base;
        index_i = idx; base_is_sp_i = sp; sp_chk_idle_i = chk;
        @(negedge clk);
        start_i = 1'b0; pred_i = ~pred; base_i = ~base; index_i = idx ^ 64'h55;
        esz_i = ~esz; base_is_sp_i = ~sp;
        e_ptr = 0; nreq = 0; cyc = 0; got_done = 1'b0;
        while (!got_done && cyc < 2000) begin
            step_lf();
            if (done_o) begin
                got_done = 1'b1;
            end else if (rd_valid_o && lf[0]) begin
                while (e_ptr < nel && !pred[e_ptr * (esize / 8)]) e_ptr++;
                a = base + idx + 64'(e_ptr);
                check("R2 read address", rd_addr_o, a);
                e_ptr++;
                nreq++;
                rd_ready_i = 1'b1;
                @(negedge clk);
                rd_ready_i = 1'b0;
                for (int w = 0; w < int'(lf[2:1]); w++) @(negedge clk);
                rsp_valid_i = 1'b1;
                rsp_data_i  = mem_byte(a);
                @(negedge clk);
                rsp_valid_i = 1'b0;
                rsp_data_i  = 8'hEE;
            end else begin
                start_i = poke && (cyc == 2);
                if (start_i) begin
                    base_i = base ^ 64'h10; pred_i = ~pred; base_is_sp_i = 1'b0;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            cyc++;
        end
        check(poke ? "R7 done after busy start" : "R8 done seen", 64'(got_done), 64'd1);
        check(poke ? "R7 result" : "R3 R4 result", result_o, exp_res);
        check(flt_rq, 64'(fault_o), 64'(exp_fault));
        check(cnt_rq, 64'(nreq), 64'(nact));
        @(negedge clk);
        check("R8 done single cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset done", 64'(done_o), 64'd0);
        check("R8 reset rd_valid", 64'(rd_valid_o), 64'd0);
        check("R8 reset busy", 64'(busy_o), 64'd0);
        check("R8 reset result", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive sweep of element size and predicate, base not from SP
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 256; p++) begin
                run_op(2'(s), 8'(p), 64'h0000_1234_0000_0000 + 64'(p * 16 + s),
                       p[0] ? 64'hFFFF_FFFF_FFFF_FFFD : 64'(p * 3),
                       1'b0, p[1], 1'b0,
                       (p == 255) ? "R1 read count" : "R2 read count",
                       "R9 no fault off SP");
            end
        end

        // stack-pointer cases
        run_op(2'd0, 8'h01, 64'h8000_0003, 64'h0, 1'b1, 1'b0, 1'b0, "R5 no reads", "R5 fault");
        run_op(2'd2, 8'h10, 64'h8000_0008, 64'h4, 1'b1, 1'b1, 1'b0, "R5 no reads", "R5 fault");
        run_op(2'd1, 8'hFF, 64'h8000_0000, 64'h7, 1'b1, 1'b1, 1'b0, "R5 aligned reads", "R5 aligned no fault");
        run_op(2'd0, 8'h00, 64'h8000_0001, 64'h0, 1'b1, 1'b1, 1'b0, "R6 no reads", "R6 idle check fault");
        run_op(2'd0, 8'h00, 64'h8000_0001, 64'h0, 1'b1, 1'b0, 1'b0, "R6 no reads", "R6 idle no check");
        run_op(2'd3, 8'hFE, 64'h8000_000F, 64'h0, 1'b1, 1'b1, 1'b0, "R6 no reads", "R6 inactive bits fault");
        run_op(2'd3, 8'hFE, 64'h8000_000F, 64'h0, 1'b1, 1'b0, 1'b0, "R6 no reads", "R6 inactive bits no fault");

        // start while busy
        run_op(2'd0, 8'hA5, 64'h0000_0040, 64'h2, 1'b0, 1'b0, 1'b1, "R7 read count", "R7 no fault");
        run_op(2'd1, 8'h00, 64'h0000_0041, 64'h0, 1'b0, 1'b0, 1'b1, "R7 read count", "R7 no fault");
        run_op(2'd3, 8'h01, 64'h0000_0100, 64'h9, 1'b0, 1'b0, 1'b1, "R7 read count", "R7 no fault");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule